// File: doc/BRIEF.md
# Dual-Channel PWM Generator with Register Access

This block produces two independent pulse-width-modulated outputs and is programmed through a small word-addressed register port. Software writes the address, the write data and a write strobe, and reads back through a combinational read-data bus. One shared control word holds a configuration group for each channel. A group selects a clock divide ratio, a run request, a clock gate and the output polarity. Each channel also has its own wave register that holds the cycle length and the active time.

Each channel divides the system clock by the selected ratio, or passes the clock through undivided. It steps a counter through the programmed cycle and drives its output to the active level while the count is below the duty value. A new wave value is not applied at once. It is held in a staging copy and a per-channel busy flag is raised. The running counter takes the staged value at its next cycle wrap, or on the next clock if the channel is stopped. Until then the busy flag stays set and further wave writes to that channel are dropped. This gives glitch-free updates without any software timing.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: The control word is at byte address 0x0 and resets to all zero. Channel n owns bits 15n+6..15n of it: [3:0] divider code, [4] run request, [5] polarity, [6] clock gate. Bit 28+n is channel n's busy flag and is read-only. All other control bits read as 0, and address 0xC reads 0.
- R2: The wave register of channel n is at byte address 0x4+4n. Bits [31:16] hold the cycle length minus one and bits [15:0] hold the duty count. A read returns the last accepted write, and the register reads 0 after reset.
- R3: With divider code 4'hF the counter advances on every clock. The output is then active for min(duty, length) clocks out of every `length` clocks.
- R4: Divider codes 0, 1, 2, 3, 4, 8, 9, 10, 11 and 12 make each count last 120, 180, 240, 360, 480, 12000, 24000, 36000, 48000 and 72000 clocks respectively.
- R5: Codes 5, 6, 7, 13 and 14 have no ratio. With one of these codes the counter stays frozen, the output holds its level, and a staged wave value is not applied.
- R6: With polarity 1 the active level is high. With polarity 0 the active level is low and the output is the inverse.
- R7: A channel runs only when both its run request and its clock gate are 1. Otherwise its counter is held at 0 and its output sits at the inactive level. After reset, with polarity 0, that inactive level is high.
- R8: A duty count at or above the cycle length keeps the output active for the whole cycle. A duty count of 0 keeps it inactive.
- R9: An accepted wave write raises that channel's busy flag on the next clock. A wave write while the flag is set is ignored.
- R10: A running channel applies its staged value and clears its busy flag at the wrap from the last count to 0. A stopped channel does both on the next clock.
- R11: The two channels are independent: configuring one leaves the other's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Byte address; bits [3:2] select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address (combinational) |
| pwm_out | output | 2 | PWM outputs, bit n for channel n |

## Verification
The hardest case to reach is a wave write that lands while an earlier one is still staged on a running, divided channel. The busy window only lasts until the next wrap, and the second write must be dropped. The stimulus selects the 120-clock divider with a four-count cycle, which keeps the channel busy for hundreds of clocks. It then issues two wave writes a few clocks apart and reads the staged value back. Finally it waits past the wrap and measures the duty of the new waveform. Output checks count active clocks over a window that is a whole number of cycles, so the expected counts do not depend on the counter's phase.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

    localparam int CH_STRIDE = 15;       // bit stride of channel groups in the control word
    localparam int RDY_BASE  = 28;       // busy flag of channel n sits at RDY_BASE + n
    localparam int CODE_W    = 4;
    localparam int CNT_W     = 16;
    localparam int PRE_W     = 17;       // wide enough for the largest ratio
    localparam logic [CODE_W-1:0] CODE_DIRECT = 4'hF;

    // Field order matches bit order inside a channel group: [6] gate .. [3:0] code
    typedef struct packed {
        logic              gate;
        logic              pol;
        logic              en;
        logic [CODE_W-1:0] code;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);

    // [31:16] length minus one, [15:0] duty
    typedef struct packed {
        logic [CNT_W-1:0] len_m1;
        logic [CNT_W-1:0] duty;
    } wave_t;

    // Clocks per count for a divider code; 0 means no ratio (counter frozen)
    function automatic logic [PRE_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
        logic [PRE_W-1:0] r;
        case (code)
            4'd0:    r = 17'd120;
            4'd1:    r = 17'd180;
            4'd2:    r = 17'd240;
            4'd3:    r = 17'd360;
            4'd4:    r = 17'd480;
            4'd8:    r = 17'd12000;
            4'd9:    r = 17'd24000;
            4'd10:   r = 17'd36000;
            4'd11:   r = 17'd48000;
            4'd12:   r = 17'd72000;
            4'd15:   r = 17'd1;
            default: r = 17'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
    import pwm_dual_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    input  logic [N_CH-1:0]        absorb,
    output logic [31:0]            rdata,
    output ch_cfg_t [N_CH-1:0]     cfg,
    output wave_t   [N_CH-1:0]     stage,
    output logic    [N_CH-1:0]     busy
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_addr;

    assign idx         = addr[ADDR_W-1:2];
    assign unused_addr = addr[1:0];

    ch_cfg_t [N_CH-1:0] cfg_q;
    wave_t   [N_CH-1:0] stage_q;
    logic    [N_CH-1:0] busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            stage_q <= '0;
            busy_q  <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (we && idx == '0)
                    cfg_q[i] <= ch_cfg_t'(wdata[i*CH_STRIDE +: CFG_W]);
                if (we && idx == IDX_W'(i + 1) && !busy_q[i]) begin
                    stage_q[i] <= wave_t'(wdata);
                    busy_q[i]  <= 1'b1;
                end else if (absorb[i]) begin
                    busy_q[i]  <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == '0) begin
            for (int i = 0; i < N_CH; i++) begin
                rdata[i*CH_STRIDE +: CFG_W] = cfg_q[i];
                rdata[RDY_BASE + i]         = busy_q[i];
            end
        end else begin
            for (int i = 0; i < N_CH; i++)
                if (idx == IDX_W'(i + 1))
                    rdata = stage_q[i];
        end
    end

    assign cfg   = cfg_q;
    assign stage = stage_q;
    assign busy  = busy_q;

endmodule

// File: rtl/pwm_dual_prescale.sv
module pwm_dual_prescale
    import pwm_dual_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);

    logic [PRE_W-1:0] ratio;
    logic [PRE_W-1:0] pre_q;
    logic             has_ratio;

    assign ratio     = code_ratio(code);
    assign has_ratio = (ratio != '0);
    // >= keeps a mid-count code change from running the counter past its limit
    assign tick      = run && has_ratio && (pre_q >= ratio - PRE_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || !has_ratio)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

endmodule

// File: rtl/pwm_dual_chan.sv
module pwm_dual_chan
    import pwm_dual_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ch_cfg_t          cfg,
    input  wave_t            stage,
    input  logic             pend,
    output logic             absorb,
    output logic             pwm,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output wave_t            live
);

    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    wave_t            live_q;

    assign run = cfg.en & cfg.gate;

    pwm_dual_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .code (cfg.code),
        .tick (tick)
    );

    assign wrap   = tick && (cnt_q == live_q.len_m1);
    assign absorb = pend && (!run || wrap);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            live_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
            if (pend)
                live_q <= stage;
        end else if (tick) begin
            if (wrap) begin
                cnt_q <= '0;
                if (pend)
                    live_q <= stage;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign pwm  = (run && (cnt_q < live_q.duty)) ? cfg.pol : ~cfg.pol;
    assign cnt  = cnt_q;
    assign live = live_q;

endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
    import pwm_dual_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [N_CH-1:0]   pwm_out
);

    ch_cfg_t [N_CH-1:0]            cfg_w;
    wave_t   [N_CH-1:0]            stage_w;
    wave_t   [N_CH-1:0]            live_w;
    logic    [N_CH-1:0]            busy_w;
    logic    [N_CH-1:0]            absorb_w;
    logic    [N_CH-1:0]            run_w;
    logic    [N_CH-1:0][CNT_W-1:0] cnt_w;

    pwm_dual_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (we),
        .addr   (addr),
        .wdata  (wdata),
        .absorb (absorb_w),
        .rdata  (rdata),
        .cfg    (cfg_w),
        .stage  (stage_w),
        .busy   (busy_w)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_dual_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg_w[g]),
            .stage  (stage_w[g]),
            .pend   (busy_w[g]),
            .absorb (absorb_w[g]),
            .pwm    (pwm_out[g]),
            .run    (run_w[g]),
            .cnt    (cnt_w[g]),
            .live   (live_w[g])
        );
    end

endmodule

// File: rtl/pwm_dual_ctrl_chk.sv
module pwm_dual_ctrl_chk
    import pwm_dual_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   we,
    input logic [3:0]             addr,
    input ch_cfg_t [1:0]          cfg,
    input wave_t   [1:0]          stage,
    input wave_t   [1:0]          live,
    input logic    [1:0]          busy,
    input logic    [1:0]          run,
    input logic    [1:0][CNT_W-1:0] cnt,
    input logic    [1:0]          pwm
);

    for (genvar i = 0; i < 2; i++) begin : g_prop
        // R9: busy only rises right after a write to that channel's wave register
        a_r9_busy_rise: assert property (@(posedge clk) disable iff (rst)
            $rose(busy[i]) |-> $past(we && addr[3:2] == 2'(i + 1)));

        // R9: a wave write during busy leaves the staged value untouched
        a_r9_busy_drop: assert property (@(posedge clk) disable iff (rst)
            (we && addr[3:2] == 2'(i + 1) && busy[i]) |=> $stable(stage[i]));

        // R10: a running counter never passes the applied cycle length
        a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
            run[i] |-> cnt[i] <= live[i].len_m1);

        // R10: a running channel clears busy only on wrap, leaving the count at 0
        a_r10_clear_at_wrap: assert property (@(posedge clk) disable iff (rst)
            ($fell(busy[i]) && $past(run[i]) && run[i]) |-> cnt[i] == '0);

        // R8: duty beyond the cycle keeps the output active
        a_r8_full_duty: assert property (@(posedge clk) disable iff (rst)
            (run[i] && live[i].duty > live[i].len_m1) |-> pwm[i] == cfg[i].pol);

        // R7: a stopped channel sits at the inactive level
        a_r7_stopped_idle: assert property (@(posedge clk) disable iff (rst)
            !run[i] |-> pwm[i] != cfg[i].pol);
    end

endmodule

bind pwm_dual_ctrl pwm_dual_ctrl_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .addr  (addr),
    .cfg   (cfg_w),
    .stage (stage_w),
    .live  (live_w),
    .busy  (busy_w),
    .run   (run_w),
    .cnt   (cnt_w),
    .pwm   (pwm_out)
);

// File: tb/pwm_dual_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_dual_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we  = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pwm_dual_ctrl u_pwm_dual_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pwm_out (pwm_out)
    );

    typedef struct packed {
        logic        ch;
        logic [3:0]  code;
        logic        pol;
        logic [15:0] len_m1;
        logic [15:0] duty;
        logic [15:0] win;
        logic [15:0] hi;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'hF, 1'b1, 16'd9, 16'd3,   16'd50,  16'd15,  4'd3},  // R3 basic
        '{1'b0, 4'hF, 1'b1, 16'd9, 16'd0,   16'd50,  16'd0,   4'd8},  // R8 zero duty
        '{1'b0, 4'hF, 1'b1, 16'd9, 16'd10,  16'd50,  16'd50,  4'd8},  // R8 duty == length
        '{1'b0, 4'hF, 1'b1, 16'd9, 16'd200, 16'd50,  16'd50,  4'd8},  // R8 duty > length
        '{1'b0, 4'hF, 1'b0, 16'd9, 16'd3,   16'd50,  16'd35,  4'd6},  // R6 inverted
        '{1'b0, 4'hF, 1'b1, 16'd0, 16'd1,   16'd20,  16'd20,  4'd3},  // R3 length 1
        '{1'b0, 4'h0, 1'b1, 16'd2, 16'd1,   16'd720, 16'd240, 4'd4},  // R4 /120
        '{1'b0, 4'h1, 1'b1, 16'd1, 16'd1,   16'd720, 16'd360, 4'd4},  // R4 /180
        '{1'b1, 4'hF, 1'b1, 16'd4, 16'd2,   16'd50,  16'd20,  4'd11}, // R11 channel 1
        '{1'b1, 4'hF, 1'b0, 16'd4, 16'd1,   16'd50,  16'd40,  4'd6}   // R6 channel 1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic count_hi(input int ch, input int win, output int hi, output int other);
        hi = 0;
        other = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (pwm_out[ch])     hi++;
            if (pwm_out[1 - ch]) other++;
        end
    endtask

    function automatic logic [31:0] ctrl_word(input int ch, input logic [3:0] code, input logic pol);
        logic [31:0] g;
        g = {25'b0, 1'b1, pol, 1'b1, code};
        return g << (15 * ch);
    endfunction

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(200000 * 8);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hi, oth;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R2 / R7 reset state
        rd(4'h0, d);  check("R1 reset control", d, 32'h0);
        rd(4'h4, d);  check("R2 reset wave ch0", d, 32'h0);
        check("R7 reset outputs idle high", {30'b0, pwm_out}, 32'h3);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            wr(4'h0, 32'h0);
            wr(VECS[v].ch ? 4'h8 : 4'h4, {VECS[v].len_m1, VECS[v].duty});
            repeat (3) @(negedge clk);
            wr(4'h0, ctrl_word(int'(VECS[v].ch), VECS[v].code, VECS[v].pol));
            repeat (4) @(negedge clk);
            count_hi(int'(VECS[v].ch), int'(VECS[v].win), hi, oth);
            check($sformatf("R%0d vector %0d high count", VECS[v].req, v), hi, 32'(VECS[v].hi));
            // R11: the other channel is stopped with polarity 0, so it holds high
            check($sformatf("R11 vector %0d idle channel", v), oth, 32'(VECS[v].win));
        end

        // R9 / R10: staged update on a divided running channel
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd3, 16'd1});
        repeat (3) @(negedge clk);
        wr(4'h0, ctrl_word(0, 4'h0, 1'b1));
        repeat (10) @(negedge clk);
        wr(4'h4, {16'd3, 16'd3});
        rd(4'h0, d);  check("R9 busy raised", {31'b0, d[28]}, 32'h1);
        wr(4'h4, {16'd3, 16'd0});
        rd(4'h4, d);  check("R9 write while busy ignored", d, 32'h0003_0003);
        check("R2 wave readback", d, {16'd3, 16'd3});
        repeat (10) @(negedge clk);
        rd(4'h0, d);  check("R10 busy held before wrap", {31'b0, d[28]}, 32'h1);
        repeat (520) @(negedge clk);
        rd(4'h0, d);  check("R10 busy cleared after wrap", {31'b0, d[28]}, 32'h0);
        count_hi(0, 960, hi, oth);
        check("R10 new duty applied", hi, 32'd720);

        // R7: gate off, then gate on without run request
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd9, 16'd5});
        repeat (3) @(negedge clk);
        wr(4'h0, 32'h0000_003F);
        count_hi(0, 30, hi, oth);
        check("R7 gate cleared keeps inactive", hi, 32'd0);
        wr(4'h0, 32'h0000_004F);
        count_hi(0, 30, hi, oth);
        check("R7 run request cleared keeps inactive high", hi, 32'd30);

        // R5: code without a ratio freezes the counter
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd4, 16'd2});
        repeat (3) @(negedge clk);
        wr(4'h0, ctrl_word(0, 4'd5, 1'b1));
        count_hi(0, 40, hi, oth);
        check("R5 frozen counter holds level", hi, 32'd40);
        wr(4'h4, {16'd4, 16'd0});
        repeat (50) @(negedge clk);
        rd(4'h0, d);  check("R5 staged value not applied", {31'b0, d[28]}, 32'h1);
        check("R5 output unchanged", {31'b0, pwm_out[0]}, 32'h1);

        // R10: stopping applies the staged value on the next clock
        wr(4'h0, 32'h0);
        @(negedge clk);
        rd(4'h0, d);  check("R10 stopped channel clears busy", {31'b0, d[28]}, 32'h0);

        // R1: implemented bits only
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, d);  check("R1 control field mask", d, 32'h003F_807F);
        rd(4'hC, d);  check("R1 unused word reads zero", d, 32'h0);

        summary();
        $finish;
    end

endmodule